// File: doc/BRIEF.md
# Cascadable FIFO Depth-Expansion Slice

This block is one stage of a deeper first-in/first-out buffer built from several identical stages joined in a ring. Every stage sees the same write strobe, write data and read strobe. Two tokens travel around the ring, one for writing and one for reading. Only the stage that holds the write token stores words. Only the stage that holds the read token returns them. A stage hands a token to its neighbour when it uses its last physical location in that direction.

A stage passes a token on with a one-cycle strobe on its `xout_wr` or `xout_rd` line. That line is wired to the `xin_wr` or `xin_rd` line of the next stage, and the last stage feeds the first. The stage whose `head_sel_n` is tied low starts with both tokens. Read data leaves each stage on its own data lines, qualified by an output enable that stands in for a shared three-state bus. The system forms the overall empty and full indications by combining the active-low per-stage flags with an OR. Each combined flag is therefore asserted only when every stage asserts it.

Top module: `xpf_slice`

## Requirements
- R1: While `rst` is high at a clock edge, the stage clears its read and write locations to zero and drives `empty_n` low, `full_n` high and `rd_oe` low. The stage with `head_sel_n` low then holds both tokens and the other stages hold neither.
- R2: A write is taken only when `wr_strobe` is high, the stage holds the write token and `full_n` is high. A read is taken only when `rd_strobe` is high, the stage holds the read token and `empty_n` is high. Within a stage, words leave in the order they arrived. A read and a write may be taken in the same cycle.
- R3: `xout_wr` is high, in the same cycle, exactly when a write is taken into location DEPTH-1. The stage then gives up the write token and its write location returns to 0.
- R4: `xout_rd` is high, in the same cycle, exactly when a read is taken from location DEPTH-1. The stage then gives up the read token and its read location returns to 0.
- R5: A high `xin_wr` or `xin_rd` at a clock edge gives the stage the write or read token. Its next write goes to location 0, and its next read comes from location 0.
- R6: `rd_oe` is high in the cycle after a read is taken, and low otherwise. While it is high, `rd_data` carries the word that was read. While it is low, `rd_data` is zero.
- R7: A stage without the write token ignores `wr_strobe`, and a stage without the read token ignores `rd_strobe`. Neither its flags nor its outputs change.
- R8: `full_n` is low exactly when the stage holds DEPTH unread words. A write strobe while full is ignored, and the stored words stay intact.
- R9: `empty_n` is low exactly when the stage holds no unread words. A read strobe while empty is ignored, and `rd_oe` stays low.
- R10: A ring of N stages acts as one queue of N*DEPTH words. The OR of all `empty_n` is low only when the queue is empty, and the OR of all `full_n` is low only when it holds N*DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_sel_n | input | 1 | Low on the stage that starts with both tokens |
| wr_strobe | input | 1 | Shared write request |
| wr_data | input | WIDTH | Shared write word |
| rd_strobe | input | 1 | Shared read request |
| xin_wr | input | 1 | Write token arriving from the previous stage |
| xin_rd | input | 1 | Read token arriving from the previous stage |
| xout_wr | output | 1 | Write token leaving to the next stage |
| xout_rd | output | 1 | Read token leaving to the next stage |
| rd_data | output | WIDTH | Word read, zero when not enabled |
| rd_oe | output | 1 | Output enable for `rd_data` |
| empty_n | output | 1 | Low when the stage is empty |
| full_n | output | 1 | Low when the stage is full |

## Verification
The assertion that a stage receiving the write token has its write location at zero relies on the `xin_*` lines coming only from a ring of identical stages. In such a ring a token reaches a stage only after that stage's previous visit wrapped its location to zero. The bench therefore wires the `xout_*` lines in a closed loop and never drives `xin_*` directly. The assertions also take exactly one stage per ring with `head_sel_n` low, and the bench ties only the first stage low. Strobes are otherwise unconstrained, so the stimulus also issues writes into a full ring and reads from an empty one.

// File: rtl/xpf_pkg.sv
package xpf_pkg;
    localparam int XPF_WIDTH_DEF = 9;
    localparam int XPF_DEPTH_DEF = 16;

    // Bit positions of the two directions inside an xpf_pair_t
    localparam int XPF_BIT_WR = 1;
    localparam int XPF_BIT_RD = 0;
    localparam int XPF_NDIR   = 2;

    typedef struct packed {
        logic wr;
        logic rd;
    } xpf_pair_t;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int cnt_bits(input int depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/xpf_ring_ptr.sv
module xpf_ring_ptr #(
    parameter int DEPTH = 16,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] ptr,
    output logic          at_last
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    assign at_last = (ptr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
        end
    end

    // R3 / R4: a step from the last location lands on location zero
    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
        step && at_last |=> ptr == '0);

    // R2: the location never moves without a step
    p_hold_without_step_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr));
endmodule

// File: rtl/xpf_token.sv
module xpf_token (
    input  logic clk,
    input  logic rst,
    input  logic head_n,
    input  logic take,
    input  logic give,
    output logic hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= ~head_n;
        end else begin
            hold <= (hold & ~give) | take;
        end
    end

    // R5: an arriving token is held on the next cycle
    p_take_holds_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> hold);

    // R3 / R4: a token given away and not returned is gone
    p_give_drops_r3: assert property (@(posedge clk) disable iff (rst)
        give && !take |=> !hold);

    // R7: a token can only be given by its holder
    p_give_needs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        give |-> hold);
endmodule

// File: rtl/xpf_store.sv
module xpf_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int PW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/xpf_level.sv
module xpf_level import xpf_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic empty_n,
    output logic full_n
);
    localparam int CW = cnt_bits(DEPTH);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [CW-1:0] level;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign empty_n = (level != '0);
    assign full_n  = (level != FULLV);

    // R8 / R9: the stage is never empty and full at once
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n));

    // R8: no increment is requested while full
    p_no_inc_full_r8: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !inc);

    // R9: no decrement is requested while empty
    p_no_dec_empty_r9: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !dec);
endmodule

// File: rtl/xpf_slice.sv
module xpf_slice import xpf_pkg::*; #(
    parameter int WIDTH = XPF_WIDTH_DEF,
    parameter int DEPTH = XPF_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_sel_n,
    input  logic             wr_strobe,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_strobe,
    input  logic             xin_wr,
    input  logic             xin_rd,
    output logic             xout_wr,
    output logic             xout_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_oe,
    output logic             empty_n,
    output logic             full_n
);
    localparam int PW = ptr_bits(DEPTH);

    xpf_pair_t take, strobe, room, accept, give, hold, last;
    logic [PW-1:0]    loc [XPF_NDIR];
    logic [WIDTH-1:0] word_q;

    assign take.wr   = xin_wr;
    assign take.rd   = xin_rd;
    assign strobe.wr = wr_strobe;
    assign strobe.rd = rd_strobe;
    assign room.wr   = full_n;
    assign room.rd   = empty_n;

    // Per-direction ownership and location tracking
    for (genvar d = 0; d < XPF_NDIR; d++) begin : g_dir
        assign accept[d] = strobe[d] & hold[d] & room[d];
        assign give[d]   = accept[d] & last[d];

        xpf_ring_ptr #(
            .DEPTH (DEPTH),
            .PW    (PW)
        ) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .step    (accept[d]),
            .ptr     (loc[d]),
            .at_last (last[d])
        );

        xpf_token u_tok (
            .clk    (clk),
            .rst    (rst),
            .head_n (head_sel_n),
            .take   (take[d]),
            .give   (give[d]),
            .hold   (hold[d])
        );
    end

    xpf_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .PW    (PW)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (accept.wr),
        .waddr (loc[XPF_BIT_WR]),
        .wdata (wr_data),
        .re    (accept.rd),
        .raddr (loc[XPF_BIT_RD]),
        .rdata (word_q)
    );

    xpf_level #(
        .DEPTH (DEPTH)
    ) u_level (
        .clk     (clk),
        .rst     (rst),
        .inc     (accept.wr),
        .dec     (accept.rd),
        .empty_n (empty_n),
        .full_n  (full_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe <= 1'b0;
        end else begin
            rd_oe <= accept.rd;
        end
    end

    assign rd_data = rd_oe ? word_q : '0;
    assign xout_wr = give.wr;
    assign xout_rd = give.rd;

    // R6: the output enable only follows a read strobe on a non-empty stage
    p_oe_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(rd_strobe) && $past(empty_n));

    // R3: a write hand-off needs a write strobe on a stage with room
    p_xout_wr_cause_r3: assert property (@(posedge clk) disable iff (rst)
        xout_wr |-> wr_strobe && full_n);

    // R4: a read hand-off needs a read strobe on a stage with data
    p_xout_rd_cause_r4: assert property (@(posedge clk) disable iff (rst)
        xout_rd |-> rd_strobe && empty_n);

    // R5: an arriving write token finds the write location at zero
    p_entry_zero_wr_r5: assert property (@(posedge clk) disable iff (rst)
        xin_wr |=> loc[XPF_BIT_WR] == '0);

    // R5: an arriving read token finds the read location at zero
    p_entry_zero_rd_r5: assert property (@(posedge clk) disable iff (rst)
        xin_rd |=> loc[XPF_BIT_RD] == '0);

    // R8: a lone write strobe on a full stage leaves it full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        !full_n && wr_strobe && !rd_strobe |=> !full_n);

    // R9: a lone read strobe on an empty stage returns nothing
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        !empty_n && rd_strobe && !wr_strobe |=> !empty_n && !rd_oe);

    // R2: without strobes the flags hold still
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe && !rd_strobe |=> $stable(empty_n) && $stable(full_n));
endmodule

// File: tb/xpf_slice_test.sv
module xpf_slice_test;
    localparam int NS    = 3;
    localparam int DEPTH = 4;
    localparam int WIDTH = 9;
    localparam int CAP   = NS * DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr  = 1'b0;
    logic rd  = 1'b0;
    logic [WIDTH-1:0] wd = '0;

    logic [NS-1:0]    xo_wr, xo_rd, oe, emp_n, ful_n;
    logic [WIDTH-1:0] rdat [NS];

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int q[$];
    int occ [NS];
    int wr_total = 0;
    int rd_total = 0;
    bit exp_oe   = 1'b0;
    int exp_os   = 0;
    int exp_word = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < NS; i++) begin : g_sl
        xpf_slice #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
        ) uut (
            .clk        (clk),
            .rst        (rst),
            .head_sel_n (i != 0),
            .wr_strobe  (wr),
            .wr_data    (wd),
            .rd_strobe  (rd),
            .xin_wr     (xo_wr[(i + NS - 1) % NS]),
            .xin_rd     (xo_rd[(i + NS - 1) % NS]),
            .xout_wr    (xo_wr[i]),
            .xout_rd    (xo_rd[i]),
            .rd_data    (rdat[i]),
            .rd_oe      (oe[i]),
            .empty_n    (emp_n[i]),
            .full_n     (ful_n[i])
        );
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        q.delete();
        for (int s = 0; s < NS; s++) occ[s] = 0;
        wr_total = 0;
        rd_total = 0;
        exp_oe   = 1'b0;
    endtask

    // Registered outputs, sampled at the falling edge
    task automatic check_outputs();
        for (int s = 0; s < NS; s++) begin
            chk(emp_n[s] == (occ[s] != 0), "R9", $sformatf("empty_n[%0d]", s),
                int'(emp_n[s]), int'(occ[s] != 0));
            chk(ful_n[s] == (occ[s] != DEPTH), "R8", $sformatf("full_n[%0d]", s),
                int'(ful_n[s]), int'(occ[s] != DEPTH));
            chk(oe[s] == (exp_oe && exp_os == s), "R6", $sformatf("rd_oe[%0d]", s),
                int'(oe[s]), int'(exp_oe && exp_os == s));
            if (exp_oe && exp_os == s) begin
                chk(int'(rdat[s]) == exp_word, "R2 R5 R10", $sformatf("read word slice %0d", s),
                    int'(rdat[s]), exp_word);
            end else begin
                chk(rdat[s] == '0, "R6 R7", $sformatf("idle rd_data[%0d]", s),
                    int'(rdat[s]), 0);
            end
        end
        chk((|emp_n) == (q.size() != 0), "R10", "composite empty_n",
            int'(|emp_n), int'(q.size() != 0));
        chk((|ful_n) == (q.size() != CAP), "R10", "composite full_n",
            int'(|ful_n), int'(q.size() != CAP));
    endtask

    // One clock: drive at the falling edge, check hand-offs, update at rise
    task automatic cycle(input bit w, input bit r, input logic [WIDTH-1:0] d);
        bit wa, ra;
        int ws, wl, rs, rl;
        wr = w;
        rd = r;
        wd = d;
        #1;
        wa = w && (q.size() < CAP);
        ra = r && (q.size() > 0);
        ws = (wr_total / DEPTH) % NS;
        wl = wr_total % DEPTH;
        rs = (rd_total / DEPTH) % NS;
        rl = rd_total % DEPTH;
        for (int s = 0; s < NS; s++) begin
            chk(xo_wr[s] == (wa && s == ws && wl == DEPTH - 1), "R3",
                $sformatf("xout_wr[%0d]", s), int'(xo_wr[s]),
                int'(wa && s == ws && wl == DEPTH - 1));
            chk(xo_rd[s] == (ra && s == rs && rl == DEPTH - 1), "R4",
                $sformatf("xout_rd[%0d]", s), int'(xo_rd[s]),
                int'(ra && s == rs && rl == DEPTH - 1));
        end
        @(posedge clk);
        exp_oe = ra;
        if (ra) begin
            exp_word = q.pop_front();
            exp_os   = rs;
            occ[rs]--;
            rd_total++;
        end
        if (wa) begin
            q.push_back(int'(d));
            occ[ws]++;
            wr_total++;
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr  = 1'b0;
        rd  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        chk(emp_n == '0, "R1", "empty_n after reset", int'(emp_n), 0);
        chk(ful_n == '1, "R1", "full_n after reset", int'(ful_n), (1 << NS) - 1);
        chk(oe == '0, "R1", "rd_oe after reset", int'(oe), 0);
        check_outputs();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        do_reset();

        // R2 R3 R5 R8: fill the ring and keep writing (extras ignored)
        for (int k = 0; k < CAP + 4; k++) cycle(1'b1, 1'b0, WIDTH'(k + 1));
        // R4 R9: drain and keep reading (extras ignored)
        for (int k = 0; k < CAP + 4; k++) cycle(1'b0, 1'b1, '0);

        // R2 R10: simultaneous read and write around the ring
        cycle(1'b1, 1'b0, 9'h0aa);
        for (int k = 0; k < 3 * CAP; k++) cycle(1'b1, 1'b1, WIDTH'(k * 7 + 3));
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, '0);

        // R7 R10: mixed traffic with shifting bias
        for (int k = 0; k < 3000; k++) begin
            int bias = (k / 500) % 3;
            bit w = ($urandom % 4) < (bias == 0 ? 3 : (bias == 1 ? 1 : 2));
            bit r = ($urandom % 4) < (bias == 0 ? 1 : (bias == 1 ? 3 : 2));
            cycle(w, r, WIDTH'($urandom));
        end

        // R1: reset with words held, then restart from the head stage
        for (int k = 0; k < 7; k++) cycle(1'b1, 1'b0, WIDTH'(k + 40));
        do_reset();
        for (int k = 0; k < 1000; k++) begin
            bit w = ($urandom % 2) == 0;
            bit r = ($urandom % 3) == 0;
            cycle(w, r, WIDTH'($urandom));
        end
        for (int k = 0; k < CAP + 2; k++) cycle(1'b0, 1'b1, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule